// File: doc/BRIEF.md
# Reference Sync Event Conditioner

This block turns one of several slow, asynchronous reference signals into clean single-cycle sync events in the local oscillator clock domain. These events are what a downstream frequency-error counter needs. A source select picks the reference. Next comes a two-flop synchronizer, then a three-sample majority vote that removes short glitches. A polarity control chooses whether rising or falling transitions of the filtered level count as events, and a power-of-two prescaler thins those events to the wanted rate. A software strobe can inject an event at any time. It bypasses the input path and the prescaler.

The configuration register that feeds the select, polarity and divider fields lives outside this block. Its reset values are: select 2, rising-edge polarity, no division. The block itself only holds the restart bookkeeping for the prescaler and the output pulse register. All event generation is gated by a counter-enable input.

Top module: `refsync_conditioner`

## Requirements
- R1: `src_sel` chooses the reference: value 0 selects `sync_in[0]`, 1 selects `sync_in[1]`, 2 selects `sync_in[2]`, 3 selects `sync_in[3]`. Transitions on unselected inputs produce no events.
- R2: The selected input is synchronized by two flops and then filtered by a majority vote over its last three samples. A high level lasting one clock produces no event. A level lasting two or more clocks is accepted.
- R3: With division 0 and the block enabled, an active transition applied before rising clock edge 1 gives `sync_pulse` high after rising edge 5. The output is low after edge 4.
- R4: `edge_pol` = 0 makes rising transitions active. `edge_pol` = 1 makes falling transitions active. Transitions of the other direction produce no event.
- R5: `div_code` = k passes one active transition out of every 2^k. The first pass is the 2^k-th active transition after a prescaler restart (k = 0 passes all, k = 7 passes one in 128).
- R6: The prescaler count restarts from zero in any cycle where `src_sel`, `div_code` or `count_en` differs from its value in the previous cycle, and in every cycle where `count_en` is low.
- R7: A one-cycle `sw_sync` strobe while `count_en` is high gives `sync_pulse` high in the next cycle. This holds regardless of the reference input and the prescaler state.
- R8: A software strobe and a passed transition in the same cycle give one single-cycle pulse.
- R9: While `count_en` is low, no pulse is produced, neither from the reference nor from `sw_sync`.
- R10: Each event is exactly one clock wide on `sync_pulse`.
- R11: During and right after reset, `sync_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 4 | Asynchronous reference sources |
| src_sel | input | 2 | Reference select |
| edge_pol | input | 1 | Active transition: 0 rising, 1 falling |
| div_code | input | 3 | Prescaler exponent, divide by 2^div_code |
| count_en | input | 1 | Enables event generation |
| sw_sync | input | 1 | Single-cycle software event request |
| sync_pulse | output | 1 | One-cycle sync event |

## Verification
A table of configurations walks every select value, both polarities and divider codes from 0 to 7. A square wave drives the selected reference while the other inputs toggle twice as often. The pulse count therefore separates a correct selection from a wrong one, and a correct divider from a neighbouring one. Directed sequences separate the remaining cases:
- a one-clock glitch against a two-clock level shows that the majority filter works;
- the exact pulse cycle of the first event confirms the pipeline depth;
- a transition of the inactive direction shows that polarity is honoured;
- changing the select or the divider partway through a count shows that the count restarts;
- a software strobe coinciding with an edge shows that the two merge into one pulse.

// File: rtl/refsync_pkg.sv
package refsync_pkg;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } edge_pol_e;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/refsync_front.sv
module refsync_front #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_DEPTH  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o
);
    import refsync_pkg::*;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [VOTE_DEPTH-1:0]  hist;
    } front_st_t;

    front_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], din};
        st_d.hist = {st_q.hist[VOTE_DEPTH-2:0], st_q.sync[SYNC_STAGES-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = vote3(st_q.hist[2:0]);

endmodule

// File: rtl/refsync_prescale.sv
module refsync_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    input  logic             pol_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             edge_o,
    output logic             pass_o
);
    import refsync_pkg::*;

    localparam int CNT_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        mask      = ~({CNT_W{1'b1}} << div_i);
        if (edge_pol_e'(pol_i) == POL_FALL) edge_o = st_q.prev & ~level_i;
        else                                edge_o = ~st_q.prev & level_i;
        pass_o = 1'b0;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (edge_o) begin
            if (st_q.cnt == mask) begin
                pass_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/refsync_conditioner.sv
module refsync_conditioner #(
    parameter int NUM_SRC     = 4,
    parameter int SEL_W       = $clog2(NUM_SRC),
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sync_in,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               edge_pol,
    input  logic [DIV_W-1:0]   div_code,
    input  logic               count_en,
    input  logic               sw_sync,
    output logic               sync_pulse
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
        logic             en;
        logic             pulse;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    picked;
    logic    level;
    logic    restart;
    logic    edge_evt;
    logic    pass;

    // one-hot gating of the sources, one term per input
    logic [NUM_SRC-1:0] gated;
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
        assign gated[g] = sync_in[g] & (src_sel == SEL_W'(g));
    end
    assign picked = |gated;

    refsync_front #(
        .SYNC_STAGES(SYNC_STAGES),
        .VOTE_DEPTH (3)
    ) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (picked),
        .level_o(level)
    );

    refsync_prescale #(
        .DIV_W(DIV_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level),
        .pol_i    (edge_pol),
        .div_i    (div_code),
        .restart_i(restart),
        .edge_o   (edge_evt),
        .pass_o   (pass)
    );

    always_comb begin
        restart    = !count_en || (src_sel != st_q.sel) ||
                     (div_code != st_q.div) || (count_en != st_q.en);
        st_d       = st_q;
        st_d.sel   = src_sel;
        st_d.div   = div_code;
        st_d.en    = count_en;
        st_d.pulse = count_en & (pass | sw_sync);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sel <= SEL_W'(2);
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_pulse = st_q.pulse;

endmodule

// File: rtl/refsync_checker.sv
module refsync_checker (
    input logic clk,
    input logic rst_n,
    input logic count_en,
    input logic sw_sync,
    input logic sync_pulse,
    input logic edge_evt,
    input logic pass
);

    assert_no_pulse_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> $past(count_en));

    assert_sw_request_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sync && count_en) |=> sync_pulse);

    assert_pulse_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> ($past(sw_sync) || $past(pass)));

    assert_pass_needs_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> edge_evt);

    assert_edges_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> !edge_evt);

    // R11: output quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) assert_reset_quiet_R11: assert (!sync_pulse);
    end

endmodule

bind refsync_conditioner refsync_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .sw_sync   (sw_sync),
    .sync_pulse(sync_pulse),
    .edge_evt  (edge_evt),
    .pass      (pass)
);

// File: tb/refsync_conditioner_test.sv
`timescale 1ns/1ps
module refsync_conditioner_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sync_in = '0;
    logic [1:0] src_sel = 2'd2;
    logic       edge_pol = 1'b0;
    logic [2:0] div_code = '0;
    logic       count_en = 1'b0;
    logic       sw_sync = 1'b0;
    logic       sync_pulse;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    refsync_conditioner uut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .src_sel(src_sel),
        .edge_pol(edge_pol), .div_code(div_code), .count_en(count_en),
        .sw_sync(sw_sync), .sync_pulse(sync_pulse)
    );

    always @(negedge clk) if (sync_pulse) pulse_cnt++;

    typedef struct packed {
        logic [1:0] sel;
        logic       pol;
        logic [2:0] div;
        logic [7:0] npul;
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{sel: 2'd2, pol: 1'b0, div: 3'd0, npul: 8'd5},
        '{sel: 2'd0, pol: 1'b0, div: 3'd1, npul: 8'd6},
        '{sel: 2'd1, pol: 1'b1, div: 3'd2, npul: 8'd9},
        '{sel: 2'd3, pol: 1'b0, div: 3'd3, npul: 8'd17},
        '{sel: 2'd2, pol: 1'b1, div: 3'd0, npul: 8'd4},
        '{sel: 2'd0, pol: 1'b1, div: 3'd7, npul: 8'd130},
        '{sel: 2'd1, pol: 1'b0, div: 3'd4, npul: 8'd40}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one 12-cycle period: selected input high 6, others toggle every 3
    task automatic period(input int sel);
        for (int c = 0; c < 12; c++) begin
            for (int i = 0; i < 4; i++)
                sync_in[i] = (i == sel) ? (c < 6) : ((c % 6) < 3);
            @(negedge clk);
        end
        sync_in = '0;
    endtask

    task automatic clean_pulse(input int sel);
        sync_in[sel] = 1'b1;
        cycles(6);
        sync_in[sel] = 1'b0;
        cycles(8);
    endtask

    task automatic setup(input logic [1:0] s, input logic p, input logic [2:0] d);
        count_en = 1'b0;
        sync_in  = '0;
        cycles(8);
        src_sel  = s;
        edge_pol = p;
        div_code = d;
        cycles(2);
        count_en = 1'b1;
        cycles(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int mark;
        int got;
        // R11 reset state
        cycles(3);
        check(sync_pulse == 1'b0, "R11 in reset", sync_pulse, 0);
        rst_n = 1'b1;
        cycles(2);
        check(sync_pulse == 1'b0, "R11 after reset", sync_pulse, 0);

        // table walk: R1 select, R4 polarity, R5 division
        for (int v = 0; v < 7; v++) begin
            setup(VEC[v].sel, VEC[v].pol, VEC[v].div);
            mark = pulse_cnt;
            for (int p = 0; p < int'(VEC[v].npul); p++) period(int'(VEC[v].sel));
            cycles(10);
            got = pulse_cnt - mark;
            check(got == (int'(VEC[v].npul) >> VEC[v].div), "R1/R4/R5 vector count",
                  got, int'(VEC[v].npul) >> VEC[v].div);
        end

        // R3 latency and R10 width
        setup(2'd2, 1'b0, 3'd0);
        sync_in[2] = 1'b1;
        cycles(4);
        check(sync_pulse == 1'b0, "R3 before edge 5", sync_pulse, 0);
        cycles(1);
        check(sync_pulse == 1'b1, "R3 at edge 5", sync_pulse, 1);
        cycles(1);
        check(sync_pulse == 1'b0, "R10 one cycle wide", sync_pulse, 0);
        // R4: falling edge with rising polarity gives nothing
        mark = pulse_cnt;
        sync_in[2] = 1'b0;
        cycles(10);
        check(pulse_cnt == mark, "R4 inactive falling", pulse_cnt - mark, 0);

        // R4 falling polarity timing
        setup(2'd2, 1'b1, 3'd0);
        mark = pulse_cnt;
        sync_in[2] = 1'b1;
        cycles(10);
        check(pulse_cnt == mark, "R4 inactive rising", pulse_cnt - mark, 0);
        sync_in[2] = 1'b0;
        cycles(5);
        check(sync_pulse == 1'b1, "R4 falling at edge 5", sync_pulse, 1);

        // R2 glitch rejection
        setup(2'd2, 1'b0, 3'd0);
        mark = pulse_cnt;
        sync_in[2] = 1'b1;
        cycles(1);
        sync_in[2] = 1'b0;
        cycles(10);
        check(pulse_cnt == mark, "R2 one-cycle glitch", pulse_cnt - mark, 0);
        sync_in[2] = 1'b1;
        cycles(2);
        sync_in[2] = 1'b0;
        cycles(10);
        check(pulse_cnt == mark + 1, "R2 two-cycle level", pulse_cnt - mark, 1);

        // R7 software request with large division and idle input
        setup(2'd2, 1'b0, 3'd7);
        sw_sync = 1'b1;
        cycles(1);
        sw_sync = 1'b0;
        check(sync_pulse == 1'b1, "R7 sw pulse", sync_pulse, 1);
        cycles(1);
        check(sync_pulse == 1'b0, "R7 sw pulse ends", sync_pulse, 0);

        // R8 coincidence of sw request and passed edge
        setup(2'd2, 1'b0, 3'd0);
        mark = pulse_cnt;
        sync_in[2] = 1'b1;
        cycles(4);
        sw_sync = 1'b1;
        cycles(1);
        sw_sync = 1'b0;
        check(sync_pulse == 1'b1, "R8 merged pulse", sync_pulse, 1);
        cycles(1);
        check(sync_pulse == 1'b0, "R8 single cycle", sync_pulse, 0);
        sync_in[2] = 1'b0;
        cycles(8);
        check(pulse_cnt == mark + 1, "R8 pulse total", pulse_cnt - mark, 1);

        // R6 restart on select change and divider change
        setup(2'd2, 1'b0, 3'd1);
        mark = pulse_cnt;
        clean_pulse(2);
        check(pulse_cnt == mark, "R6 first of two", pulse_cnt - mark, 0);
        src_sel = 2'd0;
        cycles(3);
        src_sel = 2'd2;
        cycles(3);
        clean_pulse(2);
        check(pulse_cnt == mark, "R6 restart on select", pulse_cnt - mark, 0);
        clean_pulse(2);
        check(pulse_cnt == mark + 1, "R6 pass after restart", pulse_cnt - mark, 1);
        clean_pulse(2);
        div_code = 3'd2;
        cycles(2);
        div_code = 3'd1;
        cycles(2);
        clean_pulse(2);
        check(pulse_cnt == mark + 1, "R6 restart on divider", pulse_cnt - mark, 1);

        // R9 disabled: no reference or sw pulses
        setup(2'd2, 1'b0, 3'd0);
        count_en = 1'b0;
        cycles(2);
        mark = pulse_cnt;
        clean_pulse(2);
        sw_sync = 1'b1;
        cycles(1);
        sw_sync = 1'b0;
        cycles(4);
        check(pulse_cnt == mark, "R9 disabled silent", pulse_cnt - mark, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule